// File: doc/BRIEF.md
# Run-Time Reprogrammable Reference Divider

This block divides an incoming reference clock by an unsigned ratio held in an active register. It emits a single-clock pulse once every ratio clocks, and that pulse feeds a phase comparator. The ratio can be rewritten while the divider runs. The write strobe carries a reload-mode flag that decides how the new value takes effect:

- In synchronous mode the value waits in a shadow register and is adopted at the end of the current count period.
- In forced mode the value replaces the active ratio and restarts the count straight away.

Ratios below 2 cannot be divided and are dropped. A restart input is meant for the first programming after power-up. It throws away any waiting ratio and starts a fresh period. A low enable freezes the whole divider in place.

Top module: `refdiv_top`

## Requirements
- R1: During reset and on the first clock after reset is released, `div_pulse` and `pending` are 0. The first pulse is seen RST_RATIO-1 rising edges after the last reset edge. After that, pulses come every RST_RATIO edges (default RST_RATIO = 8).
- R2: With enable high, each pulse lasts exactly one clock. Consecutive pulses are exactly the active ratio apart, for any ratio from 2 up to 2047.
- R3: A valid strobe with `force_mode` = 0 sets `pending` to 1 from the next edge. The current period still ends on schedule. The new ratio governs the periods after that boundary, and `pending` returns to 0 on the edge that follows the boundary pulse.
- R4: A synchronous strobe sampled on the edge that ends a period (`div_pulse` high in that cycle) is used for the very next period, and `pending` stays 0.
- R5: A valid strobe with `force_mode` = 1, sampled on edge E, reloads the count at once, so the next pulse appears ratio-1 edges after E. Any value waiting in the shadow register is discarded, and `pending` is 0 after E.
- R6: A strobe carrying 0 or 1 in either mode has no effect. The ratio, the pulse timing and `pending` all stay as they were.
- R7: While `enable` is 0 the divider holds its count, ratios and `pending`, produces no pulse, and ignores strobes. After `enable` returns high, it resumes from the held count.
- R8: `restart` = 1 on an edge clears `pending` and reloads the count with ratio-1. The ratio used is the value strobed in that same cycle if it is valid, in either mode, and otherwise the active ratio.
- R9: When several synchronous strobes arrive within one period, the last valid one is the ratio adopted at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | 1 = running, 0 = frozen (powerdown) |
| ratio_in | input | RATIO_W (11) | New division ratio |
| ratio_ld | input | 1 | Write strobe for `ratio_in` |
| force_mode | input | 1 | Reload mode: 0 = at period end, 1 = immediate |
| restart | input | 1 | Discard the waiting ratio and restart the count |
| div_pulse | output | 1 | One-clock pulse per division period |
| pending | output | 1 | A synchronous ratio is waiting for the boundary |

## Verification
The collision that matters is a ratio write landing on the same edge as the terminal reload. The bench provokes it by raising the synchronous strobe in the exact cycle `div_pulse` is high. It then expects the next pulse at the new ratio, with `pending` never raised. The same edge is also hit with an invalid forced strobe, which must leave the normal boundary reload untouched. A restart arriving while a shadow ratio waits is judged by `pending` dropping and by where the next pulse falls.

// File: rtl/refdiv_pkg.sv
// Shared definitions for the reference divider.
// Assumes: ratios are unsigned; the smallest divisible ratio is MIN_RATIO.
package refdiv_pkg;
    typedef enum logic {
        RELOAD_SYNC  = 1'b0,
        RELOAD_FORCE = 1'b1
    } reload_mode_e;

    localparam int unsigned MIN_RATIO = 2;
endpackage

// File: rtl/refdiv_ratio_ctl.sv
// Ratio control: validates incoming ratios, keeps the active and shadow
// ratios, and tells the counter when to reload and with which ratio.
// Assumes: tc is the counter's terminal flag from the same clock domain;
// nothing changes while enable is low.
module refdiv_ratio_ctl #(
    parameter int unsigned W         = 11,
    parameter int unsigned RST_RATIO = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic [W-1:0]              ratio_in,
    input  logic                      ratio_ld,
    input  refdiv_pkg::reload_mode_e  mode,
    input  logic                      restart,
    input  logic                      tc,
    output logic                      load_now,
    output logic [W-1:0]              load_val,
    output logic [W-1:0]              active_ratio,
    output logic                      pending
);
    localparam logic [W-1:0] MIN_R = W'(refdiv_pkg::MIN_RATIO);
    localparam logic [W-1:0] RST_V = W'(RST_RATIO);

    logic [W-1:0] active_q, shadow_q;
    logic         pend_q;
    logic         ld_ok, force_ok, sync_ok;

    // Classify the strobe: valid value, then split by reload mode.
    always_comb begin
        ld_ok    = ratio_ld && (ratio_in >= MIN_R);
        force_ok = ld_ok && (mode == refdiv_pkg::RELOAD_FORCE);
        sync_ok  = ld_ok && (mode == refdiv_pkg::RELOAD_SYNC);
    end

    // Pick the reload trigger and value; restart outranks force, force outranks terminal.
    always_comb begin
        load_now = restart || force_ok || tc;
        if (restart)
            load_val = ld_ok ? ratio_in : active_q;
        else if (force_ok)
            load_val = ratio_in;
        else if (sync_ok)
            load_val = ratio_in;
        else if (pend_q)
            load_val = shadow_q;
        else
            load_val = active_q;
    end

    // Ratio registers: adopt on reload, otherwise park synchronous writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= RST_V;
            shadow_q <= RST_V;
            pend_q   <= 1'b0;
        end else if (enable) begin
            if (load_now) begin
                active_q <= load_val;
                pend_q   <= 1'b0;
            end else if (sync_ok) begin
                shadow_q <= ratio_in;
                pend_q   <= 1'b1;
            end
        end
    end

    assign active_ratio = active_q;
    assign pending      = pend_q;

    p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(active_q) && $stable(shadow_q) && $stable(pend_q))
        else $error("ratio state moved while disabled");

    p_bad_ratio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_ld && (ratio_in < MIN_R) && !restart && !tc)
        |=> $stable(active_q) && $stable(shadow_q) && $stable(pend_q))
        else $error("invalid ratio changed state");

    p_pend_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(ratio_ld && (mode == refdiv_pkg::RELOAD_SYNC)))
        else $error("pending rose without a synchronous strobe");

    p_force_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && force_ok) |=> !pend_q)
        else $error("forced load left a pending ratio");

    p_restart_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && restart) |=> !pend_q)
        else $error("restart left a pending ratio");

    p_active_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active_q >= MIN_R)
        else $error("active ratio below minimum");
endmodule

// File: rtl/refdiv_counter.sv
// Down counter: runs from ratio-1 to 0 and flags the 0 state as terminal.
// Assumes: load_val is always at least 2, so a reload never lands on 0.
module refdiv_counter #(
    parameter int unsigned W         = 11,
    parameter int unsigned RST_RATIO = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          load_now,
    input  logic [W-1:0]  load_val,
    output logic [W-1:0]  count,
    output logic          tc
);
    localparam logic [W-1:0] ONE   = W'(1);
    localparam logic [W-1:0] RST_C = W'(RST_RATIO - 1);

    logic [W-1:0] count_q;

    // Count state: reload on request, step down otherwise, freeze when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= RST_C;
        else if (enable) begin
            if (load_now)
                count_q <= load_val - ONE;
            else
                count_q <= count_q - ONE;
        end
    end

    assign count = count_q;
    assign tc    = (count_q == '0);

    p_hold_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(count_q))
        else $error("count moved while disabled");

    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tc) |=> !tc)
        else $error("terminal state repeated");
endmodule

// File: rtl/refdiv_top.sv
// Reference divider top: wires ratio control to the down counter and
// gates the terminal flag into the output pulse.
// Assumes: a single clock; all inputs synchronous to clk.
module refdiv_top #(
    parameter int unsigned RATIO_W   = 11,
    parameter int unsigned RST_RATIO = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               ratio_ld,
    input  logic               force_mode,
    input  logic               restart,
    output logic               div_pulse,
    output logic               pending
);
    logic                 tc, load_now;
    logic [RATIO_W-1:0]   load_val, active_ratio, count;
    refdiv_pkg::reload_mode_e mode;

    assign mode = refdiv_pkg::reload_mode_e'(force_mode);

    refdiv_ratio_ctl #(.W(RATIO_W), .RST_RATIO(RST_RATIO)) ctl_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .ratio_in(ratio_in), .ratio_ld(ratio_ld), .mode(mode),
        .restart(restart), .tc(tc),
        .load_now(load_now), .load_val(load_val),
        .active_ratio(active_ratio), .pending(pending)
    );

    refdiv_counter #(.W(RATIO_W), .RST_RATIO(RST_RATIO)) cnt_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .load_now(load_now), .load_val(load_val),
        .count(count), .tc(tc)
    );

    // Output pulse: terminal state while running.
    assign div_pulse = enable && tc;

    p_pulse_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse)
        else $error("pulse wider than one clock");

    p_count_lt_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count < active_ratio)
        else $error("count outside active period");
endmodule

// File: tb/refdiv_top_tb_top.sv
`timescale 1ns/1ps
module refdiv_top_tb_top;
    localparam int W = 11;

    logic         clk = 1'b0;
    logic         rst_n, enable, ratio_ld, force_mode, restart;
    logic [W-1:0] ratio_in;
    logic         div_pulse, pending;

    always #2.5 clk = ~clk;

    refdiv_top #(.RATIO_W(W), .RST_RATIO(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .ratio_in(ratio_in), .ratio_ld(ratio_ld), .force_mode(force_mode),
        .restart(restart), .div_pulse(div_pulse), .pending(pending)
    );

    int    cyc = 0;
    int    exp_q[$];
    int    vectors = 0;
    int    fails = 0;
    bit    mon_on = 0;
    string req_tag = "R1";
    int    next_p, cur_r;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Monitor: pops the expected pulse cycles and compares them with what appears.
    always @(negedge clk) begin
        if (mon_on) begin
            if (div_pulse) begin
                if (exp_q.size() == 0)
                    check(1'b0, req_tag, cyc, -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    check(e == cyc, req_tag, cyc, e);
                end
            end else if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                int e;
                e = exp_q.pop_front();
                check(1'b0, req_tag, -1, e);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Driver side of the scoreboard: push the next n expected pulse cycles.
    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(next_p);
            next_p += cur_r;
        end
    endtask

    task automatic retarget(input int r);
        next_p = next_p - cur_r + r;
        cur_r  = r;
    endtask

    task automatic sit();
        wait_cyc(next_p - cur_r);
    endtask

    task automatic drive_ld(input int r, input bit frc);
        ratio_in   = r[W-1:0];
        force_mode = frc;
        ratio_ld   = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int p;
        rst_n = 1'b0; enable = 1'b1; ratio_ld = 1'b0;
        force_mode = 1'b0; restart = 1'b0; ratio_in = '0;
        repeat (3) tick();
        check(div_pulse == 1'b0, "R1", int'(div_pulse), 0);
        rst_n = 1'b1;
        check(div_pulse == 1'b0, "R1", int'(div_pulse), 0);
        check(pending == 1'b0, "R1", int'(pending), 0);
        mon_on = 1;
        next_p = cyc + 7; cur_r = 8;
        run(3); sit();

        // R3: synchronous load mid-period waits for the boundary.
        p = cyc; req_tag = "R3";
        tick(); tick(); drive_ld(5, 1'b0);
        tick(); ratio_ld = 1'b0;
        check(pending == 1'b1, "R3", int'(pending), 1);
        run(1); retarget(5);
        wait_cyc(p + 8);
        check(pending == 1'b1, "R3", int'(pending), 1);
        tick();
        check(pending == 1'b0, "R3", int'(pending), 0);
        run(3); sit();

        // R9: two synchronous loads in one period, last one wins.
        req_tag = "R9";
        tick(); drive_ld(6, 1'b0);
        tick(); drive_ld(3, 1'b0);
        tick(); ratio_ld = 1'b0;
        run(1); retarget(3); run(3); sit();
        check(pending == 1'b0, "R9", int'(pending), 0);

        // R4: synchronous load in the terminal cycle takes effect at once.
        req_tag = "R4";
        drive_ld(4, 1'b0);
        tick(); ratio_ld = 1'b0;
        check(pending == 1'b0, "R4", int'(pending), 0);
        retarget(4); run(3); sit();

        // R6: invalid ratios in both modes, including on the terminal edge.
        req_tag = "R6";
        drive_ld(1, 1'b1);
        tick(); drive_ld(0, 1'b0);
        tick(); drive_ld(1, 1'b0);
        tick(); ratio_ld = 1'b0;
        check(pending == 1'b0, "R6", int'(pending), 0);
        run(3); sit();

        // R5: forced load discards a waiting synchronous ratio.
        req_tag = "R5";
        tick(); drive_ld(6, 1'b0);
        tick(); ratio_ld = 1'b0;
        check(pending == 1'b1, "R5", int'(pending), 1);
        drive_ld(9, 1'b1);
        tick(); ratio_ld = 1'b0;
        check(pending == 1'b0, "R5", int'(pending), 0);
        next_p = cyc + 8; cur_r = 9;
        run(2); sit();

        // R2: smallest and largest ratio.
        req_tag = "R2";
        drive_ld(2, 1'b1);
        tick(); ratio_ld = 1'b0;
        next_p = cyc + 1; cur_r = 2;
        run(5); sit();
        drive_ld(2047, 1'b1);
        tick(); ratio_ld = 1'b0;
        next_p = cyc + 2046; cur_r = 2047;
        run(1); sit();
        drive_ld(5, 1'b1);
        tick(); ratio_ld = 1'b0;
        next_p = cyc + 4; cur_r = 5;
        run(2); sit();

        // R7: powerdown freezes the divider and ignores strobes.
        p = cyc; req_tag = "R7";
        tick(); tick(); enable = 1'b0;
        tick(); drive_ld(3, 1'b0);
        tick(); drive_ld(7, 1'b1);
        tick(); ratio_ld = 1'b0;
        check(pending == 1'b0, "R7", int'(pending), 0);
        check(div_pulse == 1'b0, "R7", int'(div_pulse), 0);
        wait_cyc(p + 12);
        check(div_pulse == 1'b0, "R7", int'(div_pulse), 0);
        enable = 1'b1;
        next_p += 10;
        run(2); sit();

        // R8: restart without a load clears pending and restarts the count.
        req_tag = "R8";
        tick(); drive_ld(7, 1'b0);
        tick(); ratio_ld = 1'b0;
        check(pending == 1'b1, "R8", int'(pending), 1);
        restart = 1'b1;
        tick(); restart = 1'b0;
        check(pending == 1'b0, "R8", int'(pending), 0);
        next_p = cyc + 4; cur_r = 5;
        run(2); sit();
        // R8: restart together with a synchronous load uses the new ratio.
        tick(); tick(); restart = 1'b1; drive_ld(6, 1'b0);
        tick(); restart = 1'b0; ratio_ld = 1'b0;
        check(pending == 1'b0, "R8", int'(pending), 0);
        next_p = cyc + 5; cur_r = 6;
        run(3); sit();

        repeat (3) tick();
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule